// File: doc/BRIEF.md
# Flat Panel Output Signal Conditioner

This block sits between a panel timing generator and the pins of a flat panel. It receives two complete sets of panel signals: horizontal sync, vertical sync, data-enable and pixel data. One set comes from the chip's own panel timing logic. The other is the raw input timing and pixel stream. A single 64-bit control word, written by a host over a simple select/write-enable bus, chooses which set reaches the panel. The same word sets the active level of each of the three timing outputs and decides whether the panel shift clock runs for the whole frame or only while pixels are being shown.

Both sources are presented with active-high timing. Every panel output is taken from a register on the pixel clock, so the two sources leave the block with the same one-cycle latency and the same edge alignment. The shift clock is the inverted pixel clock passed through an enable gate. Its rising edge therefore falls in the middle of each pixel's data-valid window. The enable only changes while the gated clock is low.

Top module: `panel_out_cond`

## Requirements
- R1: In the cycle after reset is asserted, the control word reads as zero, and the panel sync, data-enable, pixel and shift clock outputs are all 0.
- R2: The control word lives at byte offset 0x408. A write there (host_sel=1, host_we=1) stores host_wdata[31:0]. A read there (host_sel=1, host_we=0) returns the stored bits on host_rdata one cycle later, with bits 63:32 always 0. Writes to any other offset leave the word unchanged. In any cycle after a non-matching access or no read, host_rdata is 0.
- R3: Bit 30 selects the source. At 1 the panel outputs take the raw input set (src_*); at 0 they take the internally generated set (gen_*).
- R4: Bit 29 sets the data-enable level. At 0 pnl_de equals the selected data-enable; at 1 it is the inverse.
- R5: Bit 22 inverts pnl_hsync when set, and bit 23 inverts pnl_vsync when set. Each acts on its own output only.
- R6: Bit 27 controls the shift clock. At 1 pnl_sclk pulses in every pixel cycle. At 0 it pulses only in cycles whose selected data-enable (before the polarity inversion) is active, and stays low otherwise.
- R7: Bit 31 and bits 28, 26:24 and 21:20 are stored and read back but do not change any panel output.
- R8: Every panel output changes one pixel clock after the inputs and control value that produce it, in both source modes. A control change takes effect on the output one cycle after the write.
- R9: pnl_sclk is low whenever the pixel clock is high. When enabled, it is high during the low half of the pixel clock, so no partial pulse appears when gating starts or stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when 1, read when 0 |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data, one cycle after a read |
| gen_hsync | input | 1 | Internal horizontal sync, active high |
| gen_vsync | input | 1 | Internal vertical sync, active high |
| gen_de | input | 1 | Internal data-enable, active high |
| gen_pix | input | PIX_W | Internal pixel data |
| src_hsync | input | 1 | Raw input horizontal sync, active high |
| src_vsync | input | 1 | Raw input vertical sync, active high |
| src_de | input | 1 | Raw input data-enable, active high |
| src_pix | input | PIX_W | Raw input pixel data |
| pnl_hsync | output | 1 | Panel horizontal sync |
| pnl_vsync | output | 1 | Panel vertical sync |
| pnl_de | output | 1 | Panel data-enable strobe |
| pnl_pix | output | PIX_W | Panel pixel data |
| pnl_sclk | output | 1 | Panel shift clock |

## Verification
Every cycle, the assertions check the register access rules and the one-cycle relation between each panel output and the selected inputs. That relation covers both the source selection and the three polarity inversions. They also check that the shift-clock enable follows the free-run bit and the selected data-enable. The bench's sampling can show what a clocked property cannot: the shift clock is low during the high half of the pixel clock and pulses during the low half. The bench also checks the panel outputs for each source and polarity setting and reads the control word back.

// File: rtl/pnl_out_pkg.sv
package pnl_out_pkg;
  localparam int REG_W   = 64;
  localparam int LIVE_W  = 32;
  localparam int B_PASS  = 30;
  localparam int B_DEPOL = 29;
  localparam int B_SFREE = 27;
  localparam int B_VPOL  = 23;
  localparam int B_HPOL  = 22;

  typedef struct packed {
    logic pass;
    logic de_pol;
    logic sclk_free;
    logic vs_pol;
    logic hs_pol;
  } pnl_cfg_t;

  function automatic pnl_cfg_t decode_cfg(input logic [LIVE_W-1:0] w);
    pnl_cfg_t c;
    c.pass      = w[B_PASS];
    c.de_pol    = w[B_DEPOL];
    c.sclk_free = w[B_SFREE];
    c.vs_pol    = w[B_VPOL];
    c.hs_pol    = w[B_HPOL];
    return c;
  endfunction
endpackage

// File: rtl/pnl_ctrl_regs.sv
module pnl_ctrl_regs
  import pnl_out_pkg::*;
#(
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'h408
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  output logic [LIVE_W-1:0] cfg_word
);
  localparam int PAD_W = REG_W - LIVE_W;

  logic hit;
  assign hit = host_sel && (host_addr == REG_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_word <= '0;
    end else if (hit && host_we) begin
      cfg_word <= host_wdata[LIVE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (hit && !host_we) begin
      host_rdata <= {{PAD_W{1'b0}}, cfg_word};
    end else begin
      host_rdata <= '0;
    end
  end
endmodule

// File: rtl/pnl_out_stage.sv
module pnl_out_stage
  import pnl_out_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  pnl_cfg_t         cfg,
  input  logic             gen_hsync,
  input  logic             gen_vsync,
  input  logic             gen_de,
  input  logic [PIX_W-1:0] gen_pix,
  input  logic             src_hsync,
  input  logic             src_vsync,
  input  logic             src_de,
  input  logic [PIX_W-1:0] src_pix,
  output logic             act_next,
  output logic             pnl_hsync,
  output logic             pnl_vsync,
  output logic             pnl_de,
  output logic [PIX_W-1:0] pnl_pix
);
  logic             hs_sel, vs_sel, de_sel;
  logic [PIX_W-1:0] pix_sel;

  always_comb begin
    if (cfg.pass) begin
      hs_sel  = src_hsync;
      vs_sel  = src_vsync;
      de_sel  = src_de;
      pix_sel = src_pix;
    end else begin
      hs_sel  = gen_hsync;
      vs_sel  = gen_vsync;
      de_sel  = gen_de;
      pix_sel = gen_pix;
    end
  end

  assign act_next = de_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      pnl_hsync <= 1'b0;
      pnl_vsync <= 1'b0;
      pnl_de    <= 1'b0;
      pnl_pix   <= '0;
    end else begin
      pnl_hsync <= hs_sel ^ cfg.hs_pol;
      pnl_vsync <= vs_sel ^ cfg.vs_pol;
      pnl_de    <= de_sel ^ cfg.de_pol;
      pnl_pix   <= pix_sel;
    end
  end
endmodule

// File: rtl/pnl_sclk_gate.sv
module pnl_sclk_gate (
  input  logic clk,
  input  logic rst,
  input  logic free_run,
  input  logic act_next,
  output logic sclk_en,
  output logic pnl_sclk
);
  // The enable changes only on the rising pixel-clock edge, where the
  // inverted clock falls, so the gated output never shows a partial pulse.
  always_ff @(posedge clk) begin
    if (rst) sclk_en <= 1'b0;
    else     sclk_en <= free_run | act_next;
  end

  assign pnl_sclk = ~clk & sclk_en;
endmodule

// File: rtl/panel_out_cond.sv
module panel_out_cond
  import pnl_out_pkg::*;
#(
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'h408,
  parameter int                PIX_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [63:0]       host_wdata,
  output logic [63:0]       host_rdata,
  input  logic              gen_hsync,
  input  logic              gen_vsync,
  input  logic              gen_de,
  input  logic [PIX_W-1:0]  gen_pix,
  input  logic              src_hsync,
  input  logic              src_vsync,
  input  logic              src_de,
  input  logic [PIX_W-1:0]  src_pix,
  output logic              pnl_hsync,
  output logic              pnl_vsync,
  output logic              pnl_de,
  output logic [PIX_W-1:0]  pnl_pix,
  output logic              pnl_sclk
);
  logic [LIVE_W-1:0] cfg_word;
  pnl_cfg_t          cfg;
  logic              act_next;
  logic              sclk_en;

  assign cfg = decode_cfg(cfg_word);

  pnl_ctrl_regs #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_regs (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cfg_word(cfg_word)
  );

  pnl_out_stage #(.PIX_W(PIX_W)) u_stage (
    .clk(clk), .rst(rst), .cfg(cfg),
    .gen_hsync(gen_hsync), .gen_vsync(gen_vsync), .gen_de(gen_de), .gen_pix(gen_pix),
    .src_hsync(src_hsync), .src_vsync(src_vsync), .src_de(src_de), .src_pix(src_pix),
    .act_next(act_next),
    .pnl_hsync(pnl_hsync), .pnl_vsync(pnl_vsync), .pnl_de(pnl_de), .pnl_pix(pnl_pix)
  );

  pnl_sclk_gate u_gate (
    .clk(clk), .rst(rst),
    .free_run(cfg.sclk_free), .act_next(act_next),
    .sclk_en(sclk_en), .pnl_sclk(pnl_sclk)
  );
endmodule

// File: rtl/panel_out_cond_chk.sv
module panel_out_cond_chk #(
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'h408,
  parameter int                PIX_W   = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              host_sel,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic [63:0]       host_wdata,
  input logic [63:0]       host_rdata,
  input logic [31:0]       cfg_word,
  input logic              gen_hsync,
  input logic              gen_vsync,
  input logic              gen_de,
  input logic [PIX_W-1:0]  gen_pix,
  input logic              src_hsync,
  input logic              src_vsync,
  input logic              src_de,
  input logic [PIX_W-1:0]  src_pix,
  input logic              pnl_hsync,
  input logic              pnl_vsync,
  input logic              pnl_de,
  input logic [PIX_W-1:0]  pnl_pix,
  input logic              sclk_en
);
  logic rd_hit, wr_hit;
  assign rd_hit = host_sel && !host_we && (host_addr == REG_OFS);
  assign wr_hit = host_sel && host_we && (host_addr == REG_OFS);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    host_rdata[63:32] == 32'h0); // R2
  AST_RD_HIT: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> host_rdata[31:0] == $past(cfg_word)); // R2
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> host_rdata == 64'h0); // R2
  AST_WR_TAKE: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> cfg_word == $past(host_wdata[31:0])); // R2
  AST_WR_MISS: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(cfg_word)); // R2
  AST_DE_OUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pnl_de == (($past(cfg_word[30]) ? $past(src_de) : $past(gen_de)) ^ $past(cfg_word[29]))); // R4
  AST_HS_OUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pnl_hsync == (($past(cfg_word[30]) ? $past(src_hsync) : $past(gen_hsync)) ^ $past(cfg_word[22]))); // R5
  AST_VS_OUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pnl_vsync == (($past(cfg_word[30]) ? $past(src_vsync) : $past(gen_vsync)) ^ $past(cfg_word[23]))); // R5
  AST_PIX_OUT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pnl_pix == ($past(cfg_word[30]) ? $past(src_pix) : $past(gen_pix))); // R3
  AST_SCLK_WINDOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sclk_en == ($past(cfg_word[27]) | (pnl_de ^ $past(cfg_word[29])))); // R6
endmodule

bind panel_out_cond panel_out_cond_chk #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst(rst),
  .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_word(cfg_word),
  .gen_hsync(gen_hsync), .gen_vsync(gen_vsync), .gen_de(gen_de), .gen_pix(gen_pix),
  .src_hsync(src_hsync), .src_vsync(src_vsync), .src_de(src_de), .src_pix(src_pix),
  .pnl_hsync(pnl_hsync), .pnl_vsync(pnl_vsync), .pnl_de(pnl_de), .pnl_pix(pnl_pix),
  .sclk_en(sclk_en)
);

// File: tb/panel_out_cond_test.sv
`timescale 1ns/1ps
module panel_out_cond_test;
  localparam int PIX_W = 24;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS = 12'h408;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_sel = 1'b0, host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic gen_hsync = 0, gen_vsync = 0, gen_de = 0;
  logic src_hsync = 0, src_vsync = 0, src_de = 0;
  logic [PIX_W-1:0] gen_pix = '0, src_pix = '0;
  logic pnl_hsync, pnl_vsync, pnl_de, pnl_sclk;
  logic [PIX_W-1:0] pnl_pix;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] cur_cfg = 32'h0;

  always #2 clk = ~clk;

  panel_out_cond #(.ADDR_W(ADDR_W), .REG_OFS(OFS), .PIX_W(PIX_W)) uut (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .gen_hsync(gen_hsync), .gen_vsync(gen_vsync), .gen_de(gen_de), .gen_pix(gen_pix),
    .src_hsync(src_hsync), .src_vsync(src_vsync), .src_de(src_de), .src_pix(src_pix),
    .pnl_hsync(pnl_hsync), .pnl_vsync(pnl_vsync), .pnl_de(pnl_de), .pnl_pix(pnl_pix),
    .pnl_sclk(pnl_sclk)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // expected panel word {hs, vs, de, sclk_en, pix} from inputs and config
  function automatic logic [PIX_W+3:0] model(input logic [31:0] c,
      input logic ghs, gvs, gde, input logic [PIX_W-1:0] gpx,
      input logic shs, svs, sde, input logic [PIX_W-1:0] spx);
    logic hs, vs, de;
    logic [PIX_W-1:0] px;
    hs = c[30] ? shs : ghs;
    vs = c[30] ? svs : gvs;
    de = c[30] ? sde : gde;
    px = c[30] ? spx : gpx;
    return {hs ^ c[22], vs ^ c[23], de ^ c[29], c[27] | de, px};
  endfunction

  task automatic host_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk);
    host_sel = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_we = 0;
    if (a == OFS) cur_cfg = d[31:0];
  endtask

  task automatic host_read(input logic [ADDR_W-1:0] a, output logic [63:0] d);
    @(negedge clk);
    host_sel = 1; host_we = 0; host_addr = a;
    @(negedge clk);
    host_sel = 0;
    #1 d = host_rdata;
  endtask

  task automatic run_pixels(input int n, input string req, input bit dir_de, input bit de_val);
    logic [PIX_W+3:0] exp;
    bit have = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (have) begin
        chk({req, " hsync"}, {63'd0, pnl_hsync}, {63'd0, exp[PIX_W+3]});
        chk({req, " vsync"}, {63'd0, pnl_vsync}, {63'd0, exp[PIX_W+2]});
        chk({req, " de"},    {63'd0, pnl_de},    {63'd0, exp[PIX_W+1]});
        chk({req, " pix R8"}, {40'd0, pnl_pix},  {40'd0, exp[PIX_W-1:0]});
        chk("R6 sclk low phase", {63'd0, pnl_sclk}, {63'd0, exp[PIX_W]});
      end
      gen_hsync = 1'($urandom); gen_vsync = 1'($urandom);
      gen_de = dir_de ? de_val : 1'($urandom);
      gen_pix = PIX_W'($urandom);
      src_hsync = 1'($urandom); src_vsync = 1'($urandom);
      src_de = dir_de ? de_val : 1'($urandom);
      src_pix = PIX_W'($urandom);
      exp = model(cur_cfg, gen_hsync, gen_vsync, gen_de, gen_pix,
                  src_hsync, src_vsync, src_de, src_pix);
      have = 1;
      @(posedge clk);
      #0.5;
      chk("R9 sclk low while clk high", {63'd0, pnl_sclk}, 64'd0);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic [31:0] seed_v;
    seed_v = $urandom(32'h5eed_0408);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 hsync", {63'd0, pnl_hsync}, 64'd0);
    chk("R1 vsync", {63'd0, pnl_vsync}, 64'd0);
    chk("R1 de",    {63'd0, pnl_de},    64'd0);
    chk("R1 pix",   {40'd0, pnl_pix},   64'd0);
    chk("R1 sclk",  {63'd0, pnl_sclk},  64'd0);
    host_read(OFS, rd);
    chk("R1 reg zero", rd, 64'd0);

    // R2 readback, upper half zero, miss offsets
    host_write(OFS, 64'hFFFF_FFFF_FFFF_FFFF);
    host_read(OFS, rd);
    chk("R2 readback all ones", rd, 64'h0000_0000_FFFF_FFFF);
    host_write(12'h40C, 64'h0);
    host_read(OFS, rd);
    chk("R2 write other offset ignored", rd, 64'h0000_0000_FFFF_FFFF);
    host_read(12'h400, rd);
    chk("R2 read other offset zero", rd, 64'h0);
    @(negedge clk); #1;
    chk("R2 idle rdata zero", host_rdata, 64'h0);

    // R7 spare and reserved bits stored, no effect on outputs
    host_write(OFS, 64'hABCD_0000_9730_0000);
    host_read(OFS, rd);
    chk("R7 spare/reserved readback", rd, 64'h0000_0000_9730_0000);
    run_pixels(40, "R7 reserved no effect", 0, 0);

    // R3 normal and pass-through sources
    host_write(OFS, 64'h0);
    run_pixels(40, "R3 internal source", 0, 0);
    host_write(OFS, 64'h4000_0000);
    run_pixels(40, "R3 pass-through", 0, 0);

    // R4 / R5 polarity
    host_write(OFS, 64'h2000_0000);
    run_pixels(30, "R4 de active low", 0, 0);
    host_write(OFS, 64'h0040_0000);
    run_pixels(30, "R5 hsync low", 0, 0);
    host_write(OFS, 64'h0080_0000);
    run_pixels(30, "R5 vsync low", 0, 0);

    // R6 shift clock gating: blanking with gating, then free run
    host_write(OFS, 64'h0);
    run_pixels(10, "R6 gated blank", 1, 0);
    run_pixels(10, "R6 gated active", 1, 1);
    host_write(OFS, 64'h0800_0000);
    run_pixels(10, "R6 free blank", 1, 0);
    host_write(OFS, 64'h6000_0000);
    run_pixels(10, "R6 pass low-de blank", 1, 0);

    // random configurations
    for (int k = 0; k < 60; k++) begin
      host_write(OFS, {32'($urandom), 32'($urandom)});
      host_read(OFS, rd);
      chk("R2 random readback", rd, {32'd0, cur_cfg});
      run_pixels(20, "R8 random cfg", 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule